// File: doc/BRIEF.md
# Supervisory Audio Tone Manager

This block produces and recognises the supervisory audio tone of an analog cellular link. One of three tones near 6 kHz (5970 Hz, 6000 Hz, 6030 Hz) is chosen by software. The block makes a square wave at that frequency on its transmit pin. It measures the period of a square wave on its receive pin and reports which of the three tones is present. A loopback setting sends the received tone straight back out on the transmit pin. All timing is counted in cycles of one 8.064 MHz reference clock.

Software uses a two-address register interface. The control register enables the tone path, picks the tone and selects loopback. The status register reports the detected tone code and a sticky change flag. The flag is set whenever the detected code changes, so software can poll it instead of comparing codes.

Top module: `satManager`

## Requirements
- R1: After reset both registers read 0, the detected code is 00 and `txTone` is low.
- R2: While control bit 0 (enable) is 0, `txTone` stays low whatever the select and loopback bits and `rxTone` do.
- R3: With enable set, loopback clear and select (control bits 2:1) equal to 01, 10 or 11, `txTone` is a square wave with a high time and a low time each of round(8064000 / (2 × f)) clocks: 675, 672 or 669 clocks for 5970, 6000 or 6030 Hz. With select 00 the output stays low.
- R4: The receiver counts clocks between rising edges of `rxTone`. A period within ±tol of a nominal period is classified as that tone. The nominal period is round(8064000 / f) = 1351, 1344 or 1337, and tol = floor(nominal × 2000 / 10^6) = 2. The status register bits 1:0 report the code: 00 none, 01 for 5970 Hz, 10 for 6000 Hz, 11 for 6030 Hz.
- R5: Periods outside all three windows (for example 1348, 1354, 1341, 1347, 1334, 1340) never cause a tone to be reported.
- R6: A tone is reported only after 4 consecutive periods classify as that tone. Three are not enough.
- R7: Once a tone is reported, it is dropped to 00 after 8 consecutive periods that do not match it. A span of 1354 clocks with no rising edge counts as one such period.
- R8: If the received tone moves to another valid tone, the code changes directly to the new tone after 4 agreeing periods, without passing through 00.
- R9: Status bit 2 is set whenever the reported code changes. Any write to address 1 clears it.
- R10: With enable and loopback (control bit 3) set, `txTone` copies `rxTone` delayed by two clocks.
- R11: Address 0 reads back control bits 3:0 as written, and higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8.064 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address: 0 control, 1 status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| rxTone | input | 1 | Received square-wave tone |
| txTone | output | 1 | Transmitted tone |

## Verification
On every cycle the assertions check several invariants. The detected code moves only on a completed period measurement, and any such move leaves the change flag set. The agree and miss counters stay within their limits. Period results are never reported on two cycles in a row. The generated tone changes only when its divider expires or reloads. The exact divider periods, the edges of each detection window, the 4-period acquire and 8-period loss counts, a direct switch between tones and the loopback delay can be shown only by the bench scenarios. These drive chosen periods and measure `txTone` against values the bench computes from the frequencies.

// File: rtl/satPkg.sv
package satPkg;

  typedef logic [1:0] toneCode_t;

  localparam toneCode_t TONE_NONE = 2'b00;
  localparam toneCode_t TONE_LO   = 2'b01;
  localparam toneCode_t TONE_MID  = 2'b10;
  localparam toneCode_t TONE_HI   = 2'b11;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // control -> datapath
  typedef struct packed {
    logic      genOn;
    toneCode_t genSel;
    logic      loopOn;
  } satStrobes_t;

  // datapath -> control: one completed period measurement
  typedef struct packed {
    logic      valid;
    toneCode_t code;
  } satMeas_t;

endpackage

// File: rtl/satToneGen.sv
module satToneGen
  import satPkg::*;
#(
  parameter int CLK_HZ = 8064000,
  parameter int F_LO   = 5970,
  parameter int F_MID  = 6000,
  parameter int F_HI   = 6030
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  toneCode_t sel,
  output logic      toneOut
);

  localparam int HALF_LO  = (CLK_HZ + F_LO)  / (2 * F_LO);
  localparam int HALF_MID = (CLK_HZ + F_MID) / (2 * F_MID);
  localparam int HALF_HI  = (CLK_HZ + F_HI)  / (2 * F_HI);
  localparam int CNT_W    = $clog2(HALF_LO + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reloadVal;
  toneCode_t        selQ;
  logic             reloadCond;

  always_comb begin
    case (sel)
      TONE_LO:  reloadVal = CNT_W'(HALF_LO - 1);
      TONE_HI:  reloadVal = CNT_W'(HALF_HI - 1);
      default:  reloadVal = CNT_W'(HALF_MID - 1);
    endcase
  end

  assign reloadCond = !en || (sel == TONE_NONE) || (sel != selQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      selQ    <= TONE_NONE;
      toneOut <= 1'b0;
    end else begin
      selQ <= sel;
      if (reloadCond) begin
        cnt     <= reloadVal;
        toneOut <= 1'b0;
      end else if (cnt == '0) begin
        cnt     <= reloadVal;
        toneOut <= ~toneOut;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R3
  gen_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (toneOut != $past(toneOut)) |-> ($past(cnt) == '0 || $past(reloadCond)));

  // R3
  gen_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(HALF_LO - 1));

endmodule

// File: rtl/satPeriodMeter.sv
module satPeriodMeter
  import satPkg::*;
#(
  parameter int CLK_HZ  = 8064000,
  parameter int F_LO    = 5970,
  parameter int F_MID   = 6000,
  parameter int F_HI    = 6030,
  parameter int TOL_PPM = 2000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rxIn,
  output logic     rxSync,
  output satMeas_t meas
);

  localparam int NOM_LO  = (2 * CLK_HZ + F_LO)  / (2 * F_LO);
  localparam int NOM_MID = (2 * CLK_HZ + F_MID) / (2 * F_MID);
  localparam int NOM_HI  = (2 * CLK_HZ + F_HI)  / (2 * F_HI);
  localparam int TOL_LO  = NOM_LO  * TOL_PPM / 1000000;
  localparam int TOL_MID = NOM_MID * TOL_PPM / 1000000;
  localparam int TOL_HI  = NOM_HI  * TOL_PPM / 1000000;
  localparam int LIMIT   = NOM_LO + TOL_LO + 1;
  localparam int CNT_W   = $clog2(LIMIT + 1);

  logic [2:0]       syncQ;
  logic             rise;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  toneCode_t        cls;

  assign rxSync = syncQ[1];
  assign rise   = syncQ[1] & ~syncQ[2];

  always_comb begin
    cls = TONE_NONE;
    if (cnt >= CNT_W'(NOM_LO - TOL_LO) && cnt <= CNT_W'(NOM_LO + TOL_LO))
      cls = TONE_LO;
    else if (cnt >= CNT_W'(NOM_MID - TOL_MID) && cnt <= CNT_W'(NOM_MID + TOL_MID))
      cls = TONE_MID;
    else if (cnt >= CNT_W'(NOM_HI - TOL_HI) && cnt <= CNT_W'(NOM_HI + TOL_HI))
      cls = TONE_HI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      cnt   <= CNT_W'(1);
      armed <= 1'b0;
      meas  <= '0;
    end else begin
      syncQ      <= {syncQ[1:0], rxIn};
      meas.valid <= 1'b0;
      if (rise) begin
        cnt   <= CNT_W'(1);
        armed <= 1'b1;
        if (armed) begin
          meas.valid <= 1'b1;
          meas.code  <= cls;
        end
      end else if (cnt == CNT_W'(LIMIT)) begin
        cnt        <= CNT_W'(1);
        armed      <= 1'b0;
        meas.valid <= 1'b1;
        meas.code  <= TONE_NONE;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  meter_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LIMIT));

  // R4
  meas_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    meas.valid |=> !meas.valid);

endmodule

// File: rtl/satDatapath.sv
module satDatapath
  import satPkg::*;
#(
  parameter int CLK_HZ  = 8064000,
  parameter int F_LO    = 5970,
  parameter int F_MID   = 6000,
  parameter int F_HI    = 6030,
  parameter int TOL_PPM = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  satStrobes_t strobes,
  input  logic        rxTone,
  output logic        txTone,
  output satMeas_t    meas
);

  logic genTone;
  logic rxSync;

  satToneGen #(.CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI)) uGen (
    .clk     (clk),
    .rst     (rst),
    .en      (strobes.genOn),
    .sel     (strobes.genSel),
    .toneOut (genTone)
  );

  satPeriodMeter #(.CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI),
                   .TOL_PPM(TOL_PPM)) uMeter (
    .clk    (clk),
    .rst    (rst),
    .rxIn   (rxTone),
    .rxSync (rxSync),
    .meas   (meas)
  );

  always_comb begin
    if (!strobes.genOn)      txTone = 1'b0;
    else if (strobes.loopOn) txTone = rxSync;
    else                     txTone = genTone;
  end

endmodule

// File: rtl/satControl.sv
module satControl
  import satPkg::*;
#(
  parameter int AGREE_N = 4,
  parameter int LOSS_N  = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  satMeas_t          meas,
  output satStrobes_t       strobes
);

  localparam int AG_W = $clog2(AGREE_N + 1);
  localparam int MS_W = $clog2(LOSS_N);

  logic            ctrlEn;
  toneCode_t       ctrlSel;
  logic            ctrlLoop;
  toneCode_t       cand;
  toneCode_t       det;
  logic [AG_W-1:0] agree;
  logic [AG_W-1:0] nextAgree;
  logic [MS_W-1:0] miss;
  logic            flag;
  logic            acquire, keepEv, missEv, dropEv, statusWr;

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlEn   <= 1'b0;
      ctrlSel  <= TONE_NONE;
      ctrlLoop <= 1'b0;
    end else if (regWrEn && regAddr == ADDR_CTRL) begin
      ctrlEn   <= regWrData[0];
      ctrlSel  <= regWrData[2:1];
      ctrlLoop <= regWrData[3];
    end
  end

  assign strobes.genOn  = ctrlEn;
  assign strobes.genSel = ctrlSel;
  assign strobes.loopOn = ctrlLoop;

  // detection decisions
  always_comb begin
    if (meas.code == cand && agree != '0)
      nextAgree = (agree == AG_W'(AGREE_N)) ? agree : agree + 1'b1;
    else
      nextAgree = AG_W'(1);
  end

  assign acquire  = meas.valid && meas.code != TONE_NONE &&
                    nextAgree == AG_W'(AGREE_N) && meas.code != det;
  assign keepEv   = meas.valid && det != TONE_NONE && meas.code == det;
  assign missEv   = meas.valid && det != TONE_NONE && meas.code != det && !acquire;
  assign dropEv   = missEv && miss == MS_W'(LOSS_N - 1);
  assign statusWr = regWrEn && regAddr == ADDR_STAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand  <= TONE_NONE;
      agree <= '0;
      det   <= TONE_NONE;
      miss  <= '0;
      flag  <= 1'b0;
    end else begin
      if (meas.valid) begin
        if (meas.code != TONE_NONE) begin
          cand  <= meas.code;
          agree <= nextAgree;
        end else begin
          cand  <= TONE_NONE;
          agree <= '0;
        end
      end
      if (acquire)     det <= meas.code;
      else if (dropEv) det <= TONE_NONE;

      if (acquire || keepEv || dropEv) miss <= '0;
      else if (missEv)                 miss <= miss + 1'b1;

      if (acquire || dropEv) flag <= 1'b1;
      else if (statusWr)     flag <= 1'b0;
    end
  end

  // register read
  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) regRdData[3:0] = {ctrlLoop, ctrlSel, ctrlEn};
    else                      regRdData[2:0] = {flag, det};
  end

  // R6 R7 R8
  det_on_meas_chk: assert property (@(posedge clk) disable iff (rst)
    (det != $past(det)) |-> $past(meas.valid));

  // R9
  flag_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (det != $past(det)) |-> flag);

  // R6
  agree_bound_chk: assert property (@(posedge clk) disable iff (rst)
    agree <= AG_W'(AGREE_N));

  // R7
  miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
    miss <= MS_W'(LOSS_N - 1));

endmodule

// File: rtl/satManager.sv
module satManager
  import satPkg::*;
#(
  parameter int CLK_HZ  = 8064000,
  parameter int F_LO    = 5970,
  parameter int F_MID   = 6000,
  parameter int F_HI    = 6030,
  parameter int TOL_PPM = 2000,
  parameter int AGREE_N = 4,
  parameter int LOSS_N  = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxTone,
  output logic              txTone
);

  satStrobes_t strobes;
  satMeas_t    meas;

  satControl #(.AGREE_N(AGREE_N), .LOSS_N(LOSS_N), .DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .meas      (meas),
    .strobes   (strobes)
  );

  satDatapath #(.CLK_HZ(CLK_HZ), .F_LO(F_LO), .F_MID(F_MID), .F_HI(F_HI),
                .TOL_PPM(TOL_PPM)) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .rxTone  (rxTone),
    .txTone  (txTone),
    .meas    (meas)
  );

endmodule

// File: tb/satManager_test.sv
module satManager_test;

  localparam int CLK_HZ = 8064000;
  localparam int LIMIT  = 1354;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       rxTone = 1'b0;
  logic       txTone;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  satManager uut (
    .clk       (clk),
    .rst       (rst),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rxTone    (rxTone),
    .txTone    (txTone)
  );

  function automatic int freqOf(int k);
    return (k == 1) ? 5970 : (k == 2) ? 6000 : 6030;
  endfunction

  function automatic int nomOf(int k);
    return (2 * CLK_HZ + freqOf(k)) / (2 * freqOf(k));
  endfunction

  function automatic int halfOf(int k);
    return (CLK_HZ + freqOf(k)) / (2 * freqOf(k));
  endfunction

  function automatic int tolOf(int k);
    return nomOf(k) * 2000 / 1000000;
  endfunction

  function automatic int classify(int per);
    for (int k = 1; k <= 3; k++)
      if (per >= nomOf(k) - tolOf(k) && per <= nomOf(k) + tolOf(k)) return k;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    rxTone = 1'b0;
    cycles(3);
    rst = 1'b0;
    cycles(2);
  endtask

  task automatic wrReg(logic a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic rxPeriods(int per, int n);
    for (int i = 0; i < n; i++) begin
      rxTone = 1'b1;
      cycles(per / 2);
      rxTone = 1'b0;
      cycles(per - per / 2);
    end
  endtask

  task automatic measureTx(output int per, output int hi);
    int guard;
    per = 0; hi = 0;
    guard = 0;
    while (txTone !== 1'b0 && guard < 3000) begin cycles(1); guard++; end
    while (txTone !== 1'b1 && guard < 6000) begin cycles(1); guard++; end
    while (txTone === 1'b1 && guard < 9000) begin cycles(1); hi++; guard++; end
    per = hi;
    while (txTone === 1'b0 && guard < 12000) begin cycles(1); per++; guard++; end
  endtask

  task automatic trial(int per);
    logic [7:0] st;
    int exp;
    exp = classify(per);
    doReset();
    rxPeriods(per, 4);
    rdReg(1'b1, st);
    check($sformatf("R6 period %0d after three", per), st[1:0], 0);
    rxPeriods(per, 1);
    rdReg(1'b1, st);
    if (exp == 0) check($sformatf("R5 period %0d", per), st[1:0], exp);
    else          check($sformatf("R4 period %0d", per), st[1:0], exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int per, hi, seenHigh;

    doReset();
    // R1 reset state
    rdReg(1'b0, rd); check("R1 ctrl", rd, 0);
    rdReg(1'b1, rd); check("R1 status", rd, 0);
    check("R1 txTone", txTone, 0);

    // R11 readback
    wrReg(1'b0, 8'h0B);
    rdReg(1'b0, rd); check("R11 ctrl 0B", rd, 8'h0B);
    wrReg(1'b0, 8'hFF);
    rdReg(1'b0, rd); check("R11 ctrl FF", rd, 8'h0F);

    // R3 generation sweep over all selects
    for (int k = 1; k <= 3; k++) begin
      wrReg(1'b0, 8'((k << 1) | 1));
      measureTx(per, hi);
      check($sformatf("R3 period sel %0d", k), per, 2 * halfOf(k));
      check($sformatf("R3 high sel %0d", k), hi, halfOf(k));
    end

    // R3 select 00 gives low output
    wrReg(1'b0, 8'h01);
    seenHigh = 0;
    for (int i = 0; i < 1500; i++) begin cycles(1); if (txTone) seenHigh = 1; end
    check("R3 select none low", seenHigh, 0);

    // R2 disabled with select and loopback set
    wrReg(1'b0, 8'h0A);
    seenHigh = 0;
    for (int i = 0; i < 10; i++) begin
      rxTone = ~rxTone;
      for (int j = 0; j < 150; j++) begin cycles(1); if (txTone) seenHigh = 1; end
    end
    check("R2 disabled low", seenHigh, 0);

    // R10 loopback delay of two clocks
    rxTone = 1'b0;
    wrReg(1'b0, 8'h0B);
    cycles(4);
    rxTone = 1'b1;
    cycles(1); check("R10 rise not yet", txTone, 0);
    cycles(1); check("R10 rise follows", txTone, 1);
    cycles(3);
    rxTone = 1'b0;
    cycles(1); check("R10 fall not yet", txTone, 1);
    cycles(1); check("R10 fall follows", txTone, 0);

    // R4 R5 R6 window edge sweep
    for (int k = 1; k <= 3; k++) begin
      trial(nomOf(k) - tolOf(k) - 1);
      trial(nomOf(k) - tolOf(k));
      trial(nomOf(k) + tolOf(k));
      trial(nomOf(k) + tolOf(k) + 1);
    end

    // R9 flag, R8 switch, R7 loss
    doReset();
    rxPeriods(nomOf(1), 6);
    rdReg(1'b1, rd);
    check("R9 code after acquire", rd[1:0], 1);
    check("R9 flag set", rd[2], 1);
    wrReg(1'b1, 8'h00);
    rdReg(1'b1, rd);
    check("R9 flag cleared", rd[2], 0);
    check("R9 code kept", rd[1:0], 1);

    seenHigh = 0;
    for (int i = 0; i < 6; i++) begin
      rxPeriods(nomOf(3), 1);
      rdReg(1'b1, rd);
      if (rd[1:0] == 2'b00) seenHigh = 1;
    end
    rdReg(1'b1, rd);
    check("R8 switched code", rd[1:0], 3);
    check("R8 never none", seenHigh, 0);
    check("R8 flag set", rd[2], 1);
    wrReg(1'b1, 8'h00);

    cycles(7 * LIMIT - nomOf(3) - 2);
    rdReg(1'b1, rd);
    check("R7 still present", rd[1:0], 3);
    check("R7 flag quiet", rd[2], 0);
    cycles(LIMIT + 40);
    rdReg(1'b1, rd);
    check("R7 lost", rd[1:0], 0);
    check("R9 flag on loss", rd[2], 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule